// File: doc/BRIEF.md
# Clock-Lock and Power-Up Command Gate Sequencer

This block decides when a memory controller may start issuing read and write commands. A command is allowed only when two conditions both hold. First, a one-time initialisation interval after power-up has elapsed. Second, the memory's delay-locked loop has seen enough stable clock cycles to lock. The block runs on a free-running reference clock. It watches a DLL-enable control and the monitored memory clock, and it drives a single `cmd_ready` level that gates the downstream command interface.

The two conditions follow different rearm rules. The initialisation interval is a plain count of reference cycles from reset release. Once it has elapsed, it never has to be met again. The lock count counts rising edges of the monitored clock, and it starts over whenever DLL-enable goes low or the monitored clock stops for longer than a loss window. Two pending flags tell the controller which condition is still outstanding.

The monitored clock is brought into the reference domain through a synchroniser before any edge is counted. It must run slower than half the reference frequency. All control and status pins are plain levels, because no data stream passes through the block.

Top module: `clk_lock_sequencer`

## Requirements
- R1: While reset is asserted and on the first sampling after it, `cmd_ready` is 0, `init_pending` is 1 and `lock_pending` is 1.
- R2: `init_pending` clears exactly INIT_CYCLES reference cycles after reset release. It is still 1 after INIT_CYCLES-1 cycles. INIT_CYCLES = ceil(INIT_TIME_NS*1000 / REF_PERIOD_PS), which is 4000 by default.
- R3: Once `init_pending` has cleared it stays 0 until the next reset, whatever DLL-enable or the monitored clock do.
- R4: `lock_pending` clears only after LOCK_CYCLES rising edges of `mon_clk` have been counted. Each edge counts only when `dll_en` is high and the clock is not flagged lost. Edges pass a 2-stage synchroniser before they are counted.
- R5: When `dll_en` is low, `cmd_ready` is 0 in that same cycle. The lock count restarts from zero, so `lock_pending` stays 1 after `dll_en` returns high until a fresh LOCK_CYCLES edges have been seen.
- R6: If no edge of either polarity of `mon_clk` is seen for LOSS_CYCLES reference cycles, the clock is flagged lost. LOSS_CYCLES = ceil(LOSS_TIME_NS*1000 / REF_PERIOD_PS), which is 6 by default. A lost clock drops `cmd_ready` and restarts the lock count. A shorter stall has no effect.
- R7: `cmd_ready` is 1 exactly when neither condition is pending.
- R8: The lock count runs independently of the initialisation timer. Lock may complete first, and `cmd_ready` then waits for the initialisation interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| dll_en | input | 1 | DLL enable control, synchronous to `clk`; low disables and rearms the lock count |
| mon_clk | input | 1 | Monitored memory clock, sampled through a synchroniser |
| cmd_ready | output | 1 | High when memory commands may be issued |
| init_pending | output | 1 | High while the power-up initialisation interval has not yet elapsed |
| lock_pending | output | 1 | High while DLL lock is not achieved or not currently valid |

## Verification
`init_pending` is due a fixed count of reference edges after reset release. The bench therefore counts posedges since release and samples exactly at INIT_CYCLES-1 and INIT_CYCLES. A low `dll_en` acts through combinational logic, so `cmd_ready` is checked in the same half cycle in which the input is driven. The lock result depends on the monitored clock: edges pass the synchroniser and then the counter, so results appear several cycles after the edge itself. To handle this, a behavioural model advances on each reference posedge and every output is compared with it in the second half of every cycle. The explicit requirement checks are placed well clear of the transitions the model times exactly.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Ceiling conversion of a time interval into reference-clock cycles.
  function automatic int ns_to_cycles(input int time_ns, input int period_ps);
    return (time_ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  // Which admission condition is still outstanding.
  typedef struct packed {
    logic init_pend;
    logic lock_pend;
  } pend_t;

endpackage

// File: rtl/seq_activity_mon.sv
module seq_activity_mon #(
  parameter int LOSS_CYCLES = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic mon_rise,
  output logic clk_lost
);
  localparam int GW = $clog2(LOSS_CYCLES + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(LOSS_CYCLES);

  // Synchroniser chain plus one history stage for edge detection.
  logic [SYNC_STAGES:0] chain;
  logic [GW-1:0]        gap;
  logic                 any_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], mon_clk};
  end

  assign any_edge = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
  assign mon_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

  // Reference cycles since the last edge; starts saturated (no clock yet).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap <= GAP_MAX;
    else if (any_edge)      gap <= '0;
    else if (gap < GAP_MAX) gap <= gap + 1'b1;
  end

  assign clk_lost = (gap == GAP_MAX);
endmodule

// File: rtl/seq_lock_counter.sv
module seq_lock_counter #(
  parameter int LOCK_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dll_en,
  input  logic clk_lost,
  input  logic mon_rise,
  output logic locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!dll_en || clk_lost)   cnt <= '0;
    else if (mon_rise && cnt < CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign locked = (cnt == CNT_MAX);
endmodule

// File: rtl/seq_init_timer.sv
module seq_init_timer #(
  parameter int INIT_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_done
);
  localparam int TW = $clog2(INIT_CYCLES + 1);
  localparam logic [TW-1:0] T_MAX = TW'(INIT_CYCLES);

  logic [TW-1:0] tcnt;

  // Counts once after reset and then holds: never rearmed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tcnt <= '0;
    else if (tcnt < T_MAX) tcnt <= tcnt + 1'b1;
  end

  assign init_done = (tcnt == T_MAX);
endmodule

// File: rtl/clk_lock_sequencer.sv
module clk_lock_sequencer
  import seq_pkg::*;
#(
  parameter int REF_PERIOD_PS = 5000,
  parameter int INIT_TIME_NS  = 20000,
  parameter int LOCK_CYCLES   = 2048,
  parameter int LOSS_TIME_NS  = 30,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dll_en,
  input  logic mon_clk,
  output logic cmd_ready,
  output logic init_pending,
  output logic lock_pending
);
  localparam int INIT_CYCLES = ns_to_cycles(INIT_TIME_NS, REF_PERIOD_PS);
  localparam int LOSS_CYCLES = ns_to_cycles(LOSS_TIME_NS, REF_PERIOD_PS);

  logic  mon_rise;
  logic  clk_lost;
  logic  locked;
  logic  init_done;
  pend_t pend;

  seq_activity_mon #(
    .LOSS_CYCLES(LOSS_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .mon_clk  (mon_clk),
    .mon_rise (mon_rise),
    .clk_lost (clk_lost)
  );

  seq_lock_counter #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .dll_en   (dll_en),
    .clk_lost (clk_lost),
    .mon_rise (mon_rise),
    .locked   (locked)
  );

  seq_init_timer #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done)
  );

  // Lock is valid only while the DLL stays enabled and the clock runs,
  // so a disable or a loss removes readiness in the same cycle.
  always_comb begin
    pend.init_pend = ~init_done;
    pend.lock_pend = ~(locked & dll_en & ~clk_lost);
  end

  assign init_pending = pend.init_pend;
  assign lock_pending = pend.lock_pend;
  assign cmd_ready    = ~(|pend);
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic clk,
  input logic rst_n,
  input logic dll_en,
  input logic clk_lost,
  input logic cmd_ready,
  input logic init_pending,
  input logic lock_pending
);

  AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !init_pending |=> !init_pending);  // R3

  AST_DLL_OFF_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    !dll_en |=> lock_pending);  // R5

  AST_LOSS_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lost |=> lock_pending);  // R6

  AST_READY_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_lost) |-> !cmd_ready);  // R6

  AST_LOCK_NEEDS_DLL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_pending) |-> (dll_en && $past(dll_en)));  // R4

endmodule

bind clk_lock_sequencer seq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dll_en       (dll_en),
  .clk_lost     (clk_lost),
  .cmd_ready    (cmd_ready),
  .init_pending (init_pending),
  .lock_pending (lock_pending)
);

// File: tb/clk_lock_sequencer_tb.sv
`timescale 1ns/1ps
module clk_lock_sequencer_tb;
  localparam int LOCK_N = 256;
  localparam int INIT_N = 4000;   // 20000 ns at 5 ns
  localparam int LOSS_N = 6;      // 30 ns at 5 ns

  logic clk = 1'b0, rst_n = 1'b0, dll_en = 1'b0, mon_clk = 1'b0;
  logic cmd_ready, init_pending, lock_pending;
  bit   mon_run = 1'b0, done = 1'b0;
  int   checks = 0, errors = 0, rel_cyc = 0, mon_cnt = 0, wd = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  clk_lock_sequencer #(.LOCK_CYCLES(LOCK_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .dll_en(dll_en), .mon_clk(mon_clk),
    .cmd_ready(cmd_ready), .init_pending(init_pending), .lock_pending(lock_pending)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, rel_cyc);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wait_to(input int k);
    while (rel_cyc < k) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) if (rst_n) rel_cyc++;

  // Monitored clock: toggles every 2 reference cycles while running.
  always @(negedge clk) if (mon_run) begin
    mon_cnt++;
    if (mon_cnt == 2) begin mon_cnt = 0; mon_clk = ~mon_clk; end
  end

  // Behavioural reference model.
  int m_ic = 0, m_lc = 0, m_gap = LOSS_N;
  bit hist[$] = '{0, 0, 0};
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ic = 0; m_lc = 0; m_gap = LOSS_N; hist = '{0, 0, 0};
    end else begin
      bit e, r;
      e = hist[1] != hist[2];
      r = hist[1] && !hist[2];
      if (!dll_en || m_gap >= LOSS_N) m_lc = 0;
      else if (r && m_lc < LOCK_N) m_lc++;
      if (e) m_gap = 0; else if (m_gap < LOSS_N) m_gap++;
      if (m_ic < INIT_N) m_ic++;
      hist.push_front(mon_clk);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic e_init, e_lock;
      e_init = (m_ic != INIT_N);
      e_lock = !(m_lc == LOCK_N && dll_en && m_gap < LOSS_N);
      check("R2", "model init_pending", init_pending, e_init);
      check("R4", "model lock_pending", lock_pending, e_lock);
      check("R7", "model cmd_ready", cmd_ready, !e_init && !e_lock);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 100000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    #1;
    check("R1", "reset cmd_ready", cmd_ready, 1'b0);
    check("R1", "reset init_pending", init_pending, 1'b1);
    check("R1", "reset lock_pending", lock_pending, 1'b1);
    @(negedge clk);
    rst_n = 1'b1; dll_en = 1'b1; mon_run = 1'b1;

    wait_to(1500);  // R8: lock first, init still running
    check("R8", "lock done early", lock_pending, 1'b0);
    check("R8", "init still pending", init_pending, 1'b1);
    check("R8", "ready waits for init", cmd_ready, 1'b0);

    wait_to(INIT_N - 1);
    check("R2", "init pending at N-1", init_pending, 1'b1);
    wait_to(INIT_N);
    check("R2", "init done at N", init_pending, 1'b0);
    check("R7", "ready when both met", cmd_ready, 1'b1);

    wait_to(4100);  // R5: disable drops ready at once
    dll_en = 1'b0;
    #0.5;
    check("R5", "ready drops same cycle", cmd_ready, 1'b0);
    check("R5", "lock pending on disable", lock_pending, 1'b1);
    wait_to(4110);
    dll_en = 1'b1;
    wait_to(4112);
    check("R5", "lock count restarted", lock_pending, 1'b1);
    check("R3", "init stays done", init_pending, 1'b0);
    wait_to(5300);
    check("R4", "relocked", lock_pending, 1'b0);
    check("R7", "ready after relock", cmd_ready, 1'b1);

    wait_to(5400);  // R6: clock stops
    mon_run = 1'b0;
    wait_to(5430);
    check("R6", "ready drops on loss", cmd_ready, 1'b0);
    check("R6", "lock pending on loss", lock_pending, 1'b1);
    check("R3", "init unaffected by loss", init_pending, 1'b0);
    mon_run = 1'b1;
    wait_to(5460);
    check("R4", "no instant relock", lock_pending, 1'b1);
    wait_to(6700);
    check("R6", "ready after clock returns", cmd_ready, 1'b1);

    wait_to(6800);  // R6: short stall ignored
    mon_run = 1'b0;
    wait_to(6803);
    mon_run = 1'b1;
    wait_to(6812);
    check("R6", "short stall keeps ready", cmd_ready, 1'b1);
    check("R6", "short stall keeps lock", lock_pending, 1'b0);

    wait_to(7000);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule